// File: doc/BRIEF.md
# Self-Checking Memory Traffic Generator

This block sits on the user-side port of a DDR SDRAM controller and exercises it without help from any other logic. Each pass has two phases. First it writes pseudo-random words to every location of a bank × row × column grid. Then it reads the same grid back in the same order and compares every returned word, byte by byte, against a regenerated copy of the written stream. The results are a per-byte-lane pass vector and an overall pass flag. A one-cycle pulse marks the end of each pass, and the pass then begins again, without end.

Every byte lane of the local data word has its own 8-bit LFSR with its own seed. The write stream and the read expectation come from the same generators, which are reloaded at the start of each phase. The local word holds two memory beats per strobe group: the lower half of the lanes carries one clock edge and the upper half carries the other. A failing lane therefore points at one strobe group and one edge. Raising the row-count parameter widens the region under test.

Top module: `memtest_gen`

## Requirements
- R1: While reset is applied, `wr_req`, `rd_req` and `done_pulse` are low and every bit of `pass_lane` and `pass_all` is high.
- R2: A write phase issues exactly BANKS×MAX_ROW×MAX_COL write requests. The column counts fastest, then the row, then the bank. Columns run 0..MAX_COL-1, rows run 0..MAX_ROW-1, and all 2^BANK_W banks are covered. `addr` = {bank, row, col}, with the column in the low COL_W bits and the bank in the top BANK_W bits.
- R3: Byte lane i of `wdata` is bits [8i+7:8i]. Its generator starts at seed (31 + 23·i) mod 256, or 1 if that value is 0, and steps as next = {s[6:0], s[7]^s[5]^s[4]^s[3]}. The current value is presented in every cycle. It advances only after a cycle in which `wdata_req` is high.
- R4: No read request is issued until every write request of the pass has been issued and every write-data beat has been taken. `wr_req` and `rd_req` are never high together.
- R5: The read phase requests the same addresses, in the same order, as the write phase.
- R6: Each cycle in which `rdata_valid` is high during the read phase, every lane of `rdata` is compared with the next value of that lane's regenerated stream. A mismatching lane's `pass_lane` bit is low from the third cycle after that beat onward. `rdata` is ignored while `rdata_valid` is low.
- R7: Pass flags are sticky until reset, including across pass restarts. Lanes that never mismatch stay high.
- R8: `done_pulse` is high for exactly one cycle per pass. It comes only after every read beat of the pass has returned and its result is visible on `pass_lane`. The next write phase follows.
- R9: A request (`wr_req` or `rd_req`) is raised only in a cycle in which `ctl_ready` is high. The request is accepted in that same cycle.
- R10: The generators are reloaded with their seeds at the start of each phase, so every pass writes the identical data stream.
- R11: `pass_all` is high exactly when every bit of `pass_lane` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_ready | input | 1 | Controller can take a command this cycle |
| wr_req | output | 1 | Write command request |
| rd_req | output | 1 | Read command request |
| addr | output | BANK_W+ROW_W+COL_W | Command address {bank,row,col} |
| wdata_req | input | 1 | Controller takes `wdata` this cycle |
| wdata | output | 16·NUM_GROUPS | Write data word |
| rdata | input | 16·NUM_GROUPS | Read data word |
| rdata_valid | input | 1 | `rdata` carries a read beat |
| pass_lane | output | 2·NUM_GROUPS | Sticky per-lane pass flags |
| pass_all | output | 1 | Sticky overall pass flag |
| done_pulse | output | 1 | One-cycle end-of-pass marker |

## Verification
The hardest situation to reach from the ports is a single corrupted byte in the middle of a read phase. The bench must observe that exactly one flag falls on exactly the third cycle, and that the flag then stays low through the following restart. The stand-in controller stores what was written and throttles `ctl_ready`, `wdata_req` and `rdata_valid` with a pseudo-random sequence. Read data returns with queued delay. On one chosen beat of the second pass, the stand-in flips a bit in one lane. The bench compares the flag vector every cycle against a model that lowers that lane from the third cycle after the bad beat. It then runs a further clean pass, resets, and runs one more pass to confirm that only reset restores the flags.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

  typedef enum logic [2:0] {
    S_WSEED,
    S_WISSUE,
    S_WDRAIN,
    S_RSEED,
    S_RISSUE,
    S_RDRAIN,
    S_FLUSH,
    S_DONE
  } mt_state_e;

  // Maximal-length 8-bit step, taps for x^8+x^6+x^5+x^4+1
  function automatic logic [7:0] lfsr_next(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [7:0] lane_seed(input int unsigned idx);
    logic [7:0] v;
    v = 8'(31 + 23 * idx);
    if (v == 8'h00) v = 8'h01;
    return v;
  endfunction

endpackage

// File: rtl/mt_lfsr_lane.sv
module mt_lfsr_lane
  import memtest_pkg::*;
#(
  parameter logic [7:0] SEED = 8'h1F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       adv,
  output logic [7:0] q
);

  logic [7:0] q_nx;

  always_comb begin
    q_nx = q;
    if (load)     q_nx = SEED;
    else if (adv) q_nx = lfsr_next(q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= SEED;
    else        q <= q_nx;
  end

endmodule

// File: rtl/mt_addr_walk.sv
module mt_addr_walk #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 13,
  parameter int COL_W   = 10,
  parameter int MAX_ROW = 4,
  parameter int MAX_COL = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            step,
  output logic [BANK_W+ROW_W+COL_W-1:0]   addr,
  output logic                            last
);

  logic [BANK_W-1:0] bank_q, bank_nx;
  logic [ROW_W-1:0]  row_q,  row_nx;
  logic [COL_W-1:0]  col_q,  col_nx;
  logic              col_end, row_end, bank_end;

  assign col_end  = (col_q == COL_W'(MAX_COL - 1));
  assign row_end  = (row_q == ROW_W'(MAX_ROW - 1));
  assign bank_end = (bank_q == '1);
  assign last     = col_end && row_end && bank_end;
  assign addr     = {bank_q, row_q, col_q};

  always_comb begin
    bank_nx = bank_q;
    row_nx  = row_q;
    col_nx  = col_q;
    if (clr) begin
      bank_nx = '0;
      row_nx  = '0;
      col_nx  = '0;
    end else if (step) begin
      if (col_end) begin
        col_nx = '0;
        if (row_end) begin
          row_nx  = '0;
          bank_nx = bank_q + 1'b1;
        end else begin
          row_nx = row_q + 1'b1;
        end
      end else begin
        col_nx = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else begin
      bank_q <= bank_nx;
      row_q  <= row_nx;
      col_q  <= col_nx;
    end
  end

endmodule

// File: rtl/mt_lane_cmp.sv
module mt_lane_cmp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] got,
  input  logic [7:0] want,
  output logic       pass
);

  logic bad_s1, bad_s2;
  logic bad_s1_nx, pass_nx;

  always_comb begin
    bad_s1_nx = en && (got != want);
    pass_nx   = pass && !bad_s2;
  end

  // two pipeline stages then the sticky flag: result visible three cycles on (R6)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_s1 <= 1'b0;
      bad_s2 <= 1'b0;
      pass   <= 1'b1;
    end else begin
      bad_s1 <= bad_s1_nx;
      bad_s2 <= bad_s1;
      pass   <= pass_nx;
    end
  end

endmodule

// File: rtl/memtest_gen.sv
module memtest_gen
  import memtest_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 13,
  parameter int COL_W      = 10,
  parameter int MAX_ROW    = 4,
  parameter int MAX_COL    = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            ctl_ready,
  output logic                            wr_req,
  output logic                            rd_req,
  output logic [BANK_W+ROW_W+COL_W-1:0]   addr,
  input  logic                            wdata_req,
  output logic [16*NUM_GROUPS-1:0]        wdata,
  input  logic [16*NUM_GROUPS-1:0]        rdata,
  input  logic                            rdata_valid,
  output logic [2*NUM_GROUPS-1:0]         pass_lane,
  output logic                            pass_all,
  output logic                            done_pulse
);

  localparam int LANES  = 2 * NUM_GROUPS;
  localparam int BANKS  = 1 << BANK_W;
  localparam int TOTAL  = BANKS * MAX_ROW * MAX_COL;
  localparam int CNT_W  = $clog2(TOTAL + 1);

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  mt_state_e         state_q, state_nx;
  logic [CNT_W-1:0]  beat_q, beat_nx;
  logic              wr_phase, rd_phase, seeding, beat_en, walk_last;
  logic [LANES*8-1:0] gen_word;

  // reset: asserted asynchronously, released after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign wr_phase = (state_q == S_WISSUE) || (state_q == S_WDRAIN);
  assign rd_phase = (state_q == S_RISSUE) || (state_q == S_RDRAIN);
  assign seeding  = (state_q == S_WSEED)  || (state_q == S_RSEED);

  assign wr_req     = (state_q == S_WISSUE) && ctl_ready;
  assign rd_req     = (state_q == S_RISSUE) && ctl_ready;
  assign done_pulse = (state_q == S_DONE);
  assign beat_en    = (wr_phase && wdata_req) || (rd_phase && rdata_valid);

  mt_addr_walk #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .MAX_ROW(MAX_ROW),
    .MAX_COL(MAX_COL)
  ) u_walk (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (seeding),
    .step (wr_req || rd_req),
    .addr (addr),
    .last (walk_last)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    mt_lfsr_lane #(
      .SEED(lane_seed(g))
    ) u_gen (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .load (seeding),
      .adv  (beat_en),
      .q    (gen_word[g*8 +: 8])
    );

    mt_lane_cmp u_cmp (
      .clk  (clk),
      .rst_n(rst_sync_n),
      .en   (rd_phase && rdata_valid),
      .got  (rdata[g*8 +: 8]),
      .want (gen_word[g*8 +: 8]),
      .pass (pass_lane[g])
    );
  end

  assign wdata    = gen_word;
  assign pass_all = &pass_lane;

  always_comb begin
    state_nx = state_q;
    unique case (state_q)
      S_WSEED:  state_nx = S_WISSUE;
      S_WISSUE: if (wr_req && walk_last) state_nx = S_WDRAIN;
      S_WDRAIN: if (beat_q == CNT_W'(TOTAL)) state_nx = S_RSEED;
      S_RSEED:  state_nx = S_RISSUE;
      S_RISSUE: if (rd_req && walk_last) state_nx = S_RDRAIN;
      S_RDRAIN: if (beat_q == CNT_W'(TOTAL)) state_nx = S_FLUSH;
      S_FLUSH:  state_nx = S_DONE;
      S_DONE:   state_nx = S_WSEED;
      default:  state_nx = S_WSEED;
    endcase
  end

  always_comb begin
    beat_nx = beat_q;
    if (seeding)      beat_nx = '0;
    else if (beat_en) beat_nx = beat_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= S_WSEED;
      beat_q  <= '0;
    end else begin
      state_q <= state_nx;
      beat_q  <= beat_nx;
    end
  end

endmodule

// File: rtl/memtest_gen_chk.sv
module memtest_gen_chk #(
  parameter int LANES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_ready,
  input logic             wr_req,
  input logic             rd_req,
  input logic             rdata_valid,
  input logic [LANES-1:0] pass_lane,
  input logic             pass_all,
  input logic             done_pulse
);

  // R9
  req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req || rd_req) |-> ctl_ready);

  // R4
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_req && rd_req));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |=> !done_pulse);

  // R7
  pass_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pass_lane & ~$past(pass_lane)) == '0));

  // R6
  fail_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_all) |-> $past(rdata_valid, 3));

endmodule

bind memtest_gen memtest_gen_chk #(
  .LANES(2 * NUM_GROUPS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .ctl_ready  (ctl_ready),
  .wr_req     (wr_req),
  .rd_req     (rd_req),
  .rdata_valid(rdata_valid),
  .pass_lane  (pass_lane),
  .pass_all   (pass_all),
  .done_pulse (done_pulse)
);

// File: tb/memtest_gen_tb.sv
module memtest_gen_tb;

  localparam int NG    = 2;
  localparam int BW    = 2;
  localparam int RW    = 3;
  localparam int CW    = 3;
  localparam int MR    = 3;
  localparam int MC    = 4;
  localparam int LANES = 2 * NG;
  localparam int DW    = 8 * LANES;
  localparam int AW    = BW + RW + CW;
  localparam int TOTAL = (1 << BW) * MR * MC;
  localparam int LIMIT = 100000;

  logic          clk;
  logic          rst_n;
  logic          ctl_ready;
  logic          wr_req, rd_req;
  logic [AW-1:0] addr;
  logic          wdata_req;
  logic [DW-1:0] wdata;
  logic [DW-1:0] rdata;
  logic          rdata_valid;
  logic [LANES-1:0] pass_lane;
  logic          pass_all;
  logic          done_pulse;

  memtest_gen #(
    .NUM_GROUPS(NG), .BANK_W(BW), .ROW_W(RW), .COL_W(CW),
    .MAX_ROW(MR), .MAX_COL(MC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_ready(ctl_ready),
    .wr_req(wr_req), .rd_req(rd_req), .addr(addr),
    .wdata_req(wdata_req), .wdata(wdata), .rdata(rdata),
    .rdata_valid(rdata_valid), .pass_lane(pass_lane),
    .pass_all(pass_all), .done_pulse(done_pulse)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [DW-1:0] mem [1 << AW];
  int  wq[$];
  int  rq_addr[$];
  int  rq_due[$];
  logic [7:0] mw [LANES];
  int  wr_issued, wd_beats, rd_issued, rd_beats, pass_idx, inj_cyc;
  bit  prev_done, timed_out;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rnd();
    rng = rng * 32'd1664525 + 32'd1013904223;
    return int'(rng[23:8]);
  endfunction

  function automatic logic [7:0] seed_of(input int i);
    logic [7:0] v;
    v = 8'((31 + 23 * i) % 256);
    if (v == 8'h00) v = 8'h01;
    return v;
  endfunction

  function automatic logic [7:0] step8(input logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  function automatic logic [AW-1:0] exp_addr(input int idx);
    int col, row, bank;
    col  = idx % MC;
    row  = (idx / MC) % MR;
    bank = idx / (MC * MR);
    return AW'((bank << (RW + CW)) | (row << CW) | col);
  endfunction

  task automatic new_pass();
    wr_issued = 0; wd_beats = 0; rd_issued = 0; rd_beats = 0;
    for (int l = 0; l < LANES; l++) mw[l] = seed_of(l);
  endtask

  task automatic clear_bench();
    wq.delete(); rq_addr.delete(); rq_due.delete();
    new_pass();
    pass_idx = 0; inj_cyc = -1; prev_done = 1'b0;
  endtask

  task automatic run(input int passes, input bit inject);
    logic [DW-1:0] expw;
    logic [LANES-1:0] exp_pass;
    while (pass_idx < passes && !timed_out) begin
      @(negedge clk);
      cyc++;
      ctl_ready = (rnd() % 4) != 0;
      wdata_req = (wq.size() > 0) && ((rnd() % 3) != 0);
      if (rq_addr.size() > 0 && rq_due[0] <= cyc && (rnd() % 2) == 0) begin
        rdata_valid = 1'b1;
        rdata = mem[rq_addr[0]];
        if (inject && pass_idx == 1 && rd_beats == 10) begin
          rdata = rdata ^ DW'(32'h0010_0000);
          inj_cyc = cyc;
        end
      end else begin
        rdata_valid = 1'b0;
        rdata = DW'(rnd()) ^ DW'(32'hDEAD_0000);
      end
      #1;
      // R9
      if (wr_req || rd_req) chk(ctl_ready, "R9 request without ready", 64'(ctl_ready), 64'd1);
      if (wr_req) begin
        chk(wr_issued < TOTAL, "R2 write request count", 64'(wr_issued), 64'(TOTAL));
        chk(addr == exp_addr(wr_issued), "R2 write address", 64'(addr), 64'(exp_addr(wr_issued)));
        wq.push_back(int'(addr));
        wr_issued++;
      end
      if (wdata_req) begin
        for (int l = 0; l < LANES; l++) expw[l*8 +: 8] = mw[l];
        chk(wdata == expw, "R3 R10 write data", 64'(wdata), 64'(expw));
        mem[wq.pop_front()] = wdata;
        for (int l = 0; l < LANES; l++) mw[l] = step8(mw[l]);
        wd_beats++;
      end
      if (rd_req) begin
        chk(wr_issued == TOTAL && wd_beats == TOTAL, "R4 read before writes done",
            64'(wd_beats), 64'(TOTAL));
        chk(!wr_req, "R4 both requests", 64'(wr_req), 64'd0);
        chk(addr == exp_addr(rd_issued), "R5 read address", 64'(addr), 64'(exp_addr(rd_issued)));
        rq_addr.push_back(int'(addr));
        rq_due.push_back(cyc + 2);
        rd_issued++;
      end
      if (rdata_valid) begin
        void'(rq_addr.pop_front());
        void'(rq_due.pop_front());
        rd_beats++;
      end
      exp_pass = '1;
      if (inj_cyc >= 0 && cyc >= inj_cyc + 3) exp_pass[2] = 1'b0;
      // R6 R7: flag vector follows the three-cycle model, sticky across restarts
      chk(pass_lane == exp_pass, "R6 R7 pass_lane", 64'(pass_lane), 64'(exp_pass));
      if (done_pulse) begin
        chk(!prev_done, "R8 done wider than one cycle", 64'd1, 64'd0);
        chk(rd_beats == TOTAL && rd_issued == TOTAL, "R8 done before reads returned",
            64'(rd_beats), 64'(TOTAL));
        chk(pass_all == (&exp_pass), "R11 pass_all", 64'(pass_all), 64'(&exp_pass));
        new_pass();
        pass_idx++;
      end
      prev_done = done_pulse;
      if (cyc > LIMIT) begin
        timed_out = 1'b1;
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      end
    end
  endtask

  task automatic reset_check();
    chk(!wr_req && !rd_req, "R1 requests in reset", 64'({wr_req, rd_req}), 64'd0);
    chk(!done_pulse, "R1 done in reset", 64'(done_pulse), 64'd0);
    chk(pass_lane == '1, "R1 pass_lane in reset", 64'(pass_lane), 64'hF);
    chk(pass_all, "R1 R11 pass_all in reset", 64'(pass_all), 64'd1);
  endtask

  initial begin
    timed_out = 1'b0;
    rst_n = 1'b0; ctl_ready = 1'b1; wdata_req = 1'b0; rdata_valid = 1'b0; rdata = '0;
    clear_bench();
    repeat (3) @(negedge clk);
    #1 reset_check();
    @(negedge clk) rst_n = 1'b1;
    // passes 0..2: clean, one corrupted lane-2 beat, clean (flag must stay low)
    run(3, 1'b1);
    @(negedge clk);
    rst_n = 1'b0; ctl_ready = 1'b1; wdata_req = 1'b0; rdata_valid = 1'b0;
    clear_bench();
    repeat (2) @(negedge clk);
    #1 reset_check();
    @(negedge clk) rst_n = 1'b1;
    run(1, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule